// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns an asynchronous serial line, idle high, into parallel characters. The frame format is chosen at run time by level inputs. The data width is 7 or 8 bits. Parity is optional and can be even or odd. The frame ends in one or two stop bits. The transmitter in the same design uses these same inputs.

Bit timing comes from a 16-bit divisor shared with the transmitter. One bit lasts the divisor plus one system clock cycles. The line passes through a synchronizer. A falling edge starts a frame. The start bit is confirmed at its midpoint, and every later bit is sampled at its centre.

Each completed frame ends in exactly one single-cycle strobe:
- data ready, with the character valid in that same cycle;
- parity error; or
- framing error.

A frame with an error is dropped. A run-enable input switches the receiver off.

Top module: `serrx_top`

## Requirements
- R1: After reset, all three event outputs are 0 and `rxData` reads 0x00.
- R2: In 8-bit mode the data bits arrive least significant first. A good frame raises `rxReady` for one cycle, and `rxData` holds the character in that cycle.
- R3: In 7-bit mode (`wideData`=0) only 7 data bits are taken from the line, and `rxData[7]` reads 0.
- R4: With `parityOn`=1 the count of ones over the data bits and the parity bit must be even when `parityOdd`=0 and odd when `parityOdd`=1. On a mismatch, `parityErr` pulses for one cycle and `rxReady` stays 0.
- R5: With `parityOn`=0 no parity bit is expected, and `parityErr` never pulses.
- R6: A stop bit sampled low pulses `frameErr` and suppresses `rxReady`. When a frame has both a bad stop bit and bad parity, only `frameErr` fires.
- R7: With `twoStop`=1 both stop bits are sampled. A low second stop bit alone causes a framing error.
- R8: A low pulse that has ended by the start-bit midpoint is discarded with no event, and the receiver then accepts the next frame normally.
- R9: While `runEn`=0 the line is ignored and all event outputs stay 0.
- R10: Each frame produces at most one event. Each event lasts exactly one cycle.
- R11: One bit period is `baudDiv`+1 clock cycles. The start bit is re-checked (baudDiv+1)/2 cycles after the edge, with a minimum of 1, and every later bit is sampled one full period after the previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | 1 enables reception, 0 forces idle |
| baudDiv | input | 16 | Bit period minus one, in clock cycles |
| wideData | input | 1 | 1: 8 data bits, 0: 7 data bits |
| parityOn | input | 1 | 1: a parity bit follows the data |
| parityOdd | input | 1 | 0: even parity, 1: odd parity |
| twoStop | input | 1 | 1: two stop bits, 0: one |
| serIn | input | 1 | Serial input line, idle high |
| rxData | output | 8 | Received character, valid while rxReady is 1 |
| rxReady | output | 1 | One-cycle strobe for a good frame |
| parityErr | output | 1 | One-cycle strobe for a parity failure |
| frameErr | output | 1 | One-cycle strobe for a stop-bit failure |

## Verification
A faulty bit counter or frame-phase state shows up at the ports within one frame. The usual symptoms are a shifted character, a missing strobe, or the wrong error strobe after the last stop sample. A wrong divisor load moves the sample points off the bit centres. At the short divisor used by the directed tests, that corrupts data or stop checks in the first frame. Glitch and disable cases are checked by confirming that no strobe fires and that the frame which follows is still received correctly.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

  typedef struct packed {
    logic clearFrame;
    logic loadHalf;
    logic loadFull;
    logic shiftData;
    logic takePar;
    logic takeStop;
  } rxStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_REPORT
  } rxState_t;

endpackage

// File: rtl/serrx_dp.sv
module serrx_dp
  import serrx_pkg::*;
#(
  parameter int BAUD_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic [BAUD_W-1:0] baudDiv,
  input  logic              wideData,
  input  logic              parityOdd,
  input  rxStrobe_t         strb,
  output logic              tick,
  output logic              lineNow,
  output logic              startEdge,
  output logic              parBad,
  output logic              stopBad,
  output logic [DATA_W-1:0] rxData
);

  localparam int CNT_W = BAUD_W + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   linePrev;
  logic [CNT_W-1:0]       fullLen;
  logic [CNT_W-1:0]       halfLen;
  logic [CNT_W-1:0]       timer;
  logic [DATA_W-1:0]      shReg;
  logic                   parAcc;

  // synchronizer chain, resets to the idle level
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= serIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], serIn};
      end
    end
  endgenerate

  assign lineNow = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linePrev <= 1'b1;
    else       linePrev <= lineNow;
  end

  assign startEdge = linePrev & ~lineNow;

  // bit timer
  always_comb begin
    fullLen = {1'b0, baudDiv} + CNT_W'(1);
    halfLen = fullLen >> 1;
    if (halfLen == '0) halfLen = CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               timer <= '0;
    else if (strb.loadHalf)  timer <= halfLen;
    else if (strb.loadFull)  timer <= fullLen;
    else if (timer != '0)    timer <= timer - CNT_W'(1);
  end

  assign tick = (timer == CNT_W'(1));

  // data, parity and stop capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      parAcc  <= 1'b0;
      stopBad <= 1'b0;
    end else if (strb.clearFrame) begin
      shReg   <= '0;
      parAcc  <= 1'b0;
      stopBad <= 1'b0;
    end else begin
      if (strb.shiftData) begin
        shReg  <= {lineNow, shReg[DATA_W-1:1]};
        parAcc <= parAcc ^ lineNow;
      end
      if (strb.takePar)               parAcc  <= parAcc ^ lineNow;
      if (strb.takeStop && !lineNow)  stopBad <= 1'b1;
    end
  end

  assign parBad = parAcc ^ parityOdd;
  assign rxData = wideData ? shReg : {1'b0, shReg[DATA_W-1:1]};

  // R11: control may only sample on a timer expiry
  p_sample_on_tick_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftData || strb.takePar || strb.takeStop) |-> tick);

  // R11: a reload always follows a full-period sample of data
  p_reload_after_data_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftData |=> (timer != '0));

endmodule

// File: rtl/serrx_ctrl.sv
module serrx_ctrl
  import serrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      runEn,
  input  logic      wideData,
  input  logic      parityOn,
  input  logic      twoStop,
  input  logic      tick,
  input  logic      lineNow,
  input  logic      startEdge,
  input  logic      parBad,
  input  logic      stopBad,
  output rxStrobe_t strb,
  output logic      rxReady,
  output logic      parityErr,
  output logic      frameErr
);

  localparam int IDX_W = $clog2(DATA_W);

  rxState_t         state, stateNext;
  logic [IDX_W-1:0] bitIdx, bitIdxNext;
  logic             stopIdx, stopIdxNext;
  logic [IDX_W-1:0] lastBit;

  assign lastBit = wideData ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);

  always_comb begin
    strb        = '0;
    stateNext   = state;
    bitIdxNext  = bitIdx;
    stopIdxNext = stopIdx;
    if (!runEn) begin
      stateNext = S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (startEdge) begin
          strb.clearFrame = 1'b1;
          strb.loadHalf   = 1'b1;
          stateNext       = S_START;
        end
        S_START: if (tick) begin
          if (!lineNow) begin
            strb.loadFull = 1'b1;
            bitIdxNext    = '0;
            stateNext     = S_DATA;
          end else begin
            stateNext     = S_IDLE;
          end
        end
        S_DATA: if (tick) begin
          strb.shiftData = 1'b1;
          strb.loadFull  = 1'b1;
          if (bitIdx == lastBit) begin
            stopIdxNext = 1'b0;
            stateNext   = parityOn ? S_PAR : S_STOP;
          end else begin
            bitIdxNext  = bitIdx + IDX_W'(1);
          end
        end
        S_PAR: if (tick) begin
          strb.takePar  = 1'b1;
          strb.loadFull = 1'b1;
          stopIdxNext   = 1'b0;
          stateNext     = S_STOP;
        end
        S_STOP: if (tick) begin
          strb.takeStop = 1'b1;
          if (twoStop && !stopIdx) begin
            strb.loadFull = 1'b1;
            stopIdxNext   = 1'b1;
          end else begin
            stateNext     = S_REPORT;
          end
        end
        S_REPORT: stateNext = S_IDLE;
        default:  stateNext = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitIdx  <= '0;
      stopIdx <= 1'b0;
    end else begin
      state   <= stateNext;
      bitIdx  <= bitIdxNext;
      stopIdx <= stopIdxNext;
    end
  end

  // event classification: framing beats parity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReady   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      rxReady   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      if (runEn && state == S_REPORT) begin
        if (stopBad)                frameErr  <= 1'b1;
        else if (parityOn && parBad) parityErr <= 1'b1;
        else                        rxReady   <= 1'b1;
      end
    end
  end

  p_one_event_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones({rxReady, parityErr, frameErr}) <= 1);

  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |=> !rxReady);

  p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr || frameErr) |=> !(parityErr || frameErr));

  p_no_parity_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |-> $past(parityOn));

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !(rxReady || parityErr || frameErr));

endmodule

// File: rtl/serrx_top.sv
module serrx_top
  import serrx_pkg::*;
#(
  parameter int BAUD_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic [BAUD_W-1:0] baudDiv,
  input  logic              wideData,
  input  logic              parityOn,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic              serIn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              parityErr,
  output logic              frameErr
);

  rxStrobe_t strb;
  logic      tick, lineNow, startEdge, parBad, stopBad;

  serrx_dp #(
    .BAUD_W(BAUD_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .serIn(serIn), .baudDiv(baudDiv),
    .wideData(wideData), .parityOdd(parityOdd), .strb(strb),
    .tick(tick), .lineNow(lineNow), .startEdge(startEdge),
    .parBad(parBad), .stopBad(stopBad), .rxData(rxData)
  );

  serrx_ctrl #(
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .wideData(wideData),
    .parityOn(parityOn), .twoStop(twoStop), .tick(tick),
    .lineNow(lineNow), .startEdge(startEdge), .parBad(parBad),
    .stopBad(stopBad), .strb(strb), .rxReady(rxReady),
    .parityErr(parityErr), .frameErr(frameErr)
  );

endmodule

// File: tb/serrx_top_bench.sv
module serrx_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b1;
  logic [15:0] baudDiv = 16'd15;
  logic        wideData = 1'b1;
  logic        parityOn = 1'b0;
  logic        parityOdd = 1'b0;
  logic        twoStop = 1'b0;
  logic        serIn = 1'b1;
  logic [7:0]  rxData;
  logic        rxReady, parityErr, frameErr;

  int checks = 0;
  int errors = 0;
  int nReady = 0, nPe = 0, nFe = 0;
  logic [7:0] lastData = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serrx_top u_serrx_top (
    .clk(clk), .rstN(rstN), .runEn(runEn), .baudDiv(baudDiv),
    .wideData(wideData), .parityOn(parityOn), .parityOdd(parityOdd),
    .twoStop(twoStop), .serIn(serIn), .rxData(rxData),
    .rxReady(rxReady), .parityErr(parityErr), .frameErr(frameErr)
  );

  always @(negedge clk) begin
    if (rxReady) begin nReady++; lastData = rxData; end
    if (parityErr) nPe++;
    if (frameErr)  nFe++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic holdBit(input logic v);
    serIn = v;
    repeat (int'(baudDiv) + 1) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit flipPar,
                           input logic s1, input logic s2);
    logic [7:0] m;
    m = wideData ? d : {1'b0, d[6:0]};
    holdBit(1'b0);
    for (int i = 0; i < (wideData ? 8 : 7); i++) holdBit(d[i]);
    if (parityOn) holdBit((^m) ^ parityOdd ^ flipPar);
    holdBit(s1);
    if (twoStop) holdBit(s2);
    serIn = 1'b1;
    repeat (2 * (int'(baudDiv) + 1)) @(negedge clk);
  endtask

  task automatic runFrame(input string req, input logic [7:0] d, input bit flipPar,
                          input logic s1, input logic s2,
                          input int eR, input int eP, input int eF);
    int r0, p0, f0;
    r0 = nReady; p0 = nPe; f0 = nFe;
    sendFrame(d, flipPar, s1, s2);
    chk(req, "ready count", nReady - r0, eR);
    chk(req, "parity err count", nPe - p0, eP);
    chk(req, "frame err count", nFe - f0, eF);
    if (eR == 1)
      chk(req, "data", int'(lastData), int'(wideData ? d : {1'b0, d[6:0]}));
  endtask

  task automatic tReset;
    chk("R1", "ready", int'(rxReady), 0);
    chk("R1", "parity err", int'(parityErr), 0);
    chk("R1", "frame err", int'(frameErr), 0);
    chk("R1", "data", int'(rxData), 0);
  endtask

  task automatic tEightBit;
    wideData = 1; parityOn = 0; twoStop = 0;
    runFrame("R2", 8'hA5, 0, 1, 1, 1, 0, 0);
    runFrame("R2", 8'h81, 0, 1, 1, 1, 0, 0);
  endtask

  task automatic tSevenBit;
    wideData = 0;
    runFrame("R3", 8'hDA, 0, 1, 1, 1, 0, 0);
    chk("R3", "bit7", int'(lastData[7]), 0);
    wideData = 1;
  endtask

  task automatic tParity;
    parityOn = 1; parityOdd = 0;
    runFrame("R4", 8'h37, 0, 1, 1, 1, 0, 0);
    runFrame("R4", 8'h37, 1, 1, 1, 0, 1, 0);
    parityOdd = 1;
    runFrame("R4", 8'hC3, 0, 1, 1, 1, 0, 0);
    runFrame("R4", 8'hC3, 1, 1, 1, 0, 1, 0);
    parityOn = 0; parityOdd = 0;
  endtask

  task automatic tParityOff;
    parityOn = 0; parityOdd = 1;
    runFrame("R5", 8'h07, 0, 1, 1, 1, 0, 0);
    parityOdd = 0;
  endtask

  task automatic tFraming;
    runFrame("R6", 8'h5A, 0, 0, 1, 0, 0, 1);
    parityOn = 1;
    runFrame("R6", 8'h5A, 1, 0, 1, 0, 0, 1);
    parityOn = 0;
  endtask

  task automatic tTwoStop;
    twoStop = 1;
    runFrame("R7", 8'h3C, 0, 1, 1, 1, 0, 0);
    runFrame("R7", 8'h3C, 0, 1, 0, 0, 0, 1);
    twoStop = 0;
  endtask

  task automatic tGlitch;
    int r0, p0, f0;
    r0 = nReady; p0 = nPe; f0 = nFe;
    serIn = 0;
    repeat (3) @(negedge clk);
    serIn = 1;
    repeat (3 * (int'(baudDiv) + 1)) @(negedge clk);
    chk("R8", "events after glitch", (nReady - r0) + (nPe - p0) + (nFe - f0), 0);
    runFrame("R8", 8'h96, 0, 1, 1, 1, 0, 0);
  endtask

  task automatic tDisabled;
    int r0, p0, f0;
    runEn = 0;
    r0 = nReady; p0 = nPe; f0 = nFe;
    sendFrame(8'hE1, 0, 1, 1);
    sendFrame(8'hE1, 0, 0, 1);
    chk("R9", "events while off", (nReady - r0) + (nPe - p0) + (nFe - f0), 0);
    runEn = 1;
    repeat (4) @(negedge clk);
    runFrame("R9", 8'h1E, 0, 1, 1, 1, 0, 0);
  endtask

  task automatic tOneEvent;
    int hi;
    hi = 0;
    fork
      sendFrame(8'hFF, 0, 1, 1);
      repeat (14 * 16) @(negedge clk) if (rxReady) hi++;
    join
    chk("R10", "ready high cycles", hi, 1);
  endtask

  task automatic tShortBaud;
    baudDiv = 16'd7;
    runFrame("R11", 8'h6B, 0, 1, 1, 1, 0, 0);
    baudDiv = 16'd4;
    runFrame("R11", 8'hB2, 0, 1, 1, 1, 0, 0);
    baudDiv = 16'd15;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1;
    repeat (4) @(negedge clk);
    tReset();
    tEightBit();
    tSevenBit();
    tParity();
    tParityOff();
    tFraming();
    tTwoStop();
    tGlitch();
    tDisabled();
    tOneEvent();
    tShortBaud();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule